// File: doc/BRIEF.md
# Dual-Line Instruction Prefetch Buffer

This block sits between an instruction memory port and the first decode stage. It holds two 16-byte line buffers and fills them from memory one aligned line at a time. It does not wait for the decoder, so both buffers stay loaded whenever memory keeps up. The decoder sees a byte window that starts at the current read point. Each cycle it reports how many of those bytes it used, and the read point then advances. When the read point moves past the end of one buffer into the other, the drained buffer is released and refilled right away.

A redirect input carries a taken jump or branch. It throws away every prefetched byte. The next fetch is the aligned line that holds the target, and the read point is placed at the target's byte offset. If a memory response was still outstanding when the redirect arrived, that line is dropped when it comes back and is never shown to the decoder.

Top module: `ifetch_dual_buf`

## Requirements
- R1: After reset, `win_avail` is 0, and a request for the aligned line at `RESET_ADDR` is offered to memory.
- R2: Only one memory request may be outstanding. Requests are 16-byte aligned. Each accepted request is for the line after the previous one until a redirect occurs.
- R3: `win_avail` gives the number of contiguous valid bytes from the read point and never exceeds 32. It equals 16 minus the read offset when only the head buffer holds data, plus 16 when the other buffer also holds data.
- R4: Window byte i (bits 8i+7:8i of `win_bytes`) is the instruction stream byte at read address + i, for every i below both `win_avail` and `WIN_BYTES`. Lines are placed little-endian: line byte k is `mem_rsp_data[8k+7:8k]`.
- R5: `take_cnt` advances the read point by that many bytes. A buffer whose last byte has been consumed is freed. A request is offered in the same cycle whenever no request is outstanding, a buffer is free and no redirect is present.
- R6: A redirect clears both buffers. `win_avail` is 0 in the following cycle. The next request is the aligned line containing the target, and the read point starts at the target's low 4 bits.
- R7: A response to a request accepted before a redirect is discarded and does not change `win_avail`.
- R8: When a redirect falls in the same cycle as a memory response or a nonzero `take_cnt`, the redirect takes priority. The response is dropped and the consume is ignored.
- R9: When both buffers are free, the lower-addressed line is requested first, and returned lines fill the buffers in address order. With memory keeping up and no consumption, `win_avail` reaches 32 from an aligned start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| redir_valid | input | 1 | Taken jump or branch this cycle |
| redir_addr | input | ADDR_W | Byte address of the redirect target |
| take_cnt | input | TAKE_W | Bytes consumed by the decoder this cycle, at most `win_avail` |
| win_bytes | output | 8*WIN_BYTES | Byte window starting at the read point |
| win_avail | output | AVAIL_W | Contiguous valid bytes from the read point (0..32) |
| mem_req_valid | output | 1 | Line request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Aligned line address requested |
| mem_rsp_valid | input | 1 | Line returned, in request order |
| mem_rsp_data | input | 8*LINE_BYTES | Returned line, lowest address in the low byte |

## Verification
The difficult overlaps are a redirect in the same cycle as a returning memory line, and a redirect in the same cycle as a consume that crosses a buffer boundary. In both cases the redirect must win. The bench has a mode that raises the redirect exactly when its memory model drives a response, and random phases where redirects land on nonzero consume cycles. It tracks which requests belong to the current redirect generation and predicts the window from that. A stale line that was filled, or a consume that was applied, shows up as a wrong `win_avail` or a wrong window byte in the next cycle.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

  localparam int NUM_SLOTS = 2;

  // memory-side progress of the single outstanding request
  typedef enum logic [1:0] {
    FS_IDLE       = 2'd0,
    FS_WAIT_LIVE  = 2'd1,
    FS_WAIT_STALE = 2'd2
  } fetch_state_t;

endpackage

// File: rtl/ifb_slot.sv
module ifb_slot #(
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fill,
  input  logic              drain,
  input  logic [LINE_W-1:0] fill_data,
  output logic              valid,
  output logic [LINE_W-1:0] data
);

  logic valid_nxt;

  always_comb begin
    valid_nxt = valid;
    if (flush)      valid_nxt = 1'b0;
    else if (fill)  valid_nxt = 1'b1;
    else if (drain) valid_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_nxt;
  end

  // payload carries no reset; valid qualifies it
  always_ff @(posedge clk) begin
    if (fill) data <= fill_data;
  end

endmodule

// File: rtl/ifb_ctrl.sv
module ifb_ctrl
  import ifb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int TAKE_W = 3,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  input  logic [TAKE_W-1:0] take_cnt,
  input  logic              head_valid,
  input  logic              fill_free,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              head_sel,
  output logic [OFF_W-1:0]  head_off,
  output logic              fill_sel,
  output logic              fill_dst,
  output logic              fill_en,
  output logic              drain_en
);

  localparam int LN_W = ADDR_W - OFF_W;

  fetch_state_t    state_q, state_d;
  logic [LN_W-1:0] line_q, line_d;
  logic            head_sel_d, fill_sel_d, fill_dst_d;
  logic [OFF_W-1:0] head_off_d;
  logic [OFF_W:0]  off_sum;
  logic            accept;

  assign off_sum       = {1'b0, head_off} + (OFF_W+1)'(take_cnt);
  assign drain_en      = head_valid && off_sum[OFF_W] && !redir_valid;
  assign mem_req_valid = (state_q == FS_IDLE) && fill_free && !redir_valid;
  assign mem_req_addr  = {line_q, {OFF_W{1'b0}}};
  assign accept        = mem_req_valid && mem_req_ready;
  assign fill_en       = mem_rsp_valid && (state_q == FS_WAIT_LIVE) && !redir_valid;

  always_comb begin
    state_d    = state_q;
    line_d     = line_q;
    head_sel_d = head_sel;
    head_off_d = head_off;
    fill_sel_d = fill_sel;
    fill_dst_d = fill_dst;
    if (mem_rsp_valid && state_q != FS_IDLE)          state_d = FS_IDLE;
    else if (redir_valid && state_q == FS_WAIT_LIVE)  state_d = FS_WAIT_STALE;
    else if (accept)                                  state_d = FS_WAIT_LIVE;
    if (redir_valid) begin
      line_d     = redir_addr[ADDR_W-1:OFF_W];
      head_sel_d = 1'b0;
      head_off_d = redir_addr[OFF_W-1:0];
      fill_sel_d = 1'b0;
    end else begin
      head_off_d = off_sum[OFF_W-1:0];
      if (drain_en) head_sel_d = ~head_sel;
      if (accept) begin
        line_d     = line_q + 1'b1;
        fill_dst_d = fill_sel;
        fill_sel_d = ~fill_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      line_q   <= RESET_ADDR[ADDR_W-1:OFF_W];
      head_sel <= 1'b0;
      head_off <= RESET_ADDR[OFF_W-1:0];
      fill_sel <= 1'b0;
      fill_dst <= 1'b0;
    end else begin
      state_q  <= state_d;
      line_q   <= line_d;
      head_sel <= head_sel_d;
      head_off <= head_off_d;
      fill_sel <= fill_sel_d;
      fill_dst <= fill_dst_d;
    end
  end

endmodule

// File: rtl/ifb_window.sv
module ifb_window
  import ifb_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int WIN_BYTES  = 4,
  parameter int OFF_W      = 4,
  parameter int AVAIL_W    = 6
) (
  input  logic [NUM_SLOTS-1:0]                    slot_valid,
  input  logic [NUM_SLOTS-1:0][LINE_BYTES*8-1:0]  slot_data,
  input  logic                                    head_sel,
  input  logic [OFF_W-1:0]                        head_off,
  output logic [WIN_BYTES*8-1:0]                  win_bytes,
  output logic [AVAIL_W-1:0]                      win_avail
);

  localparam int IDX_W = $clog2(2*LINE_BYTES);

  logic [2*LINE_BYTES*8-1:0] joined;
  logic                      hv, ov;

  assign hv     = slot_valid[head_sel];
  assign ov     = slot_valid[~head_sel];
  assign joined = head_sel ? {slot_data[0], slot_data[1]}
                           : {slot_data[1], slot_data[0]};

  assign win_avail = hv ? (AVAIL_W'(LINE_BYTES) - AVAIL_W'(head_off)
                           + (ov ? AVAIL_W'(LINE_BYTES) : AVAIL_W'(0)))
                        : AVAIL_W'(0);

  for (genvar gi = 0; gi < WIN_BYTES; gi++) begin : g_win
    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(head_off) + IDX_W'(gi);
    assign win_bytes[gi*8 +: 8] = joined[idx*8 +: 8];
  end

endmodule

// File: rtl/ifetch_dual_buf.sv
module ifetch_dual_buf
  import ifb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int WIN_BYTES  = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int LINE_W  = LINE_BYTES*8,
  localparam int AVAIL_W = $clog2(2*LINE_BYTES+1),
  localparam int TAKE_W  = $clog2(WIN_BYTES+1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   redir_valid,
  input  logic [ADDR_W-1:0]      redir_addr,
  input  logic [TAKE_W-1:0]      take_cnt,
  output logic [WIN_BYTES*8-1:0] win_bytes,
  output logic [AVAIL_W-1:0]     win_avail,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [ADDR_W-1:0]      mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [LINE_W-1:0]      mem_rsp_data
);

  logic [NUM_SLOTS-1:0]             slot_valid;
  logic [NUM_SLOTS-1:0][LINE_W-1:0] slot_data;
  logic             head_sel, fill_sel, fill_dst, fill_en, drain_en;
  logic [OFF_W-1:0] head_off;

  ifb_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TAKE_W(TAKE_W), .RESET_ADDR(RESET_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .take_cnt(take_cnt),
    .head_valid(slot_valid[head_sel]), .fill_free(!slot_valid[fill_sel]),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .head_sel(head_sel), .head_off(head_off), .fill_sel(fill_sel),
    .fill_dst(fill_dst), .fill_en(fill_en), .drain_en(drain_en)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    ifb_slot #(.LINE_W(LINE_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .flush(redir_valid),
      .fill(fill_en && (fill_dst == 1'(g))),
      .drain(drain_en && (head_sel == 1'(g))),
      .fill_data(mem_rsp_data),
      .valid(slot_valid[g]),
      .data(slot_data[g])
    );
  end

  ifb_window #(
    .LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES), .OFF_W(OFF_W), .AVAIL_W(AVAIL_W)
  ) u_window (
    .slot_valid(slot_valid), .slot_data(slot_data),
    .head_sel(head_sel), .head_off(head_off),
    .win_bytes(win_bytes), .win_avail(win_avail)
  );

endmodule

// File: rtl/ifetch_dual_buf_chk.sv
module ifetch_dual_buf_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int WIN_BYTES  = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int AVAIL_W = $clog2(2*LINE_BYTES+1),
  localparam int TAKE_W  = $clog2(WIN_BYTES+1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic [TAKE_W-1:0] take_cnt,
  input logic [AVAIL_W-1:0] win_avail,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);

  logic [1:0]        flight_q;
  logic              stale_q;
  logic [ADDR_W-1:0] exp_q;
  logic              acc;

  assign acc = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flight_q <= '0;
      stale_q  <= 1'b0;
      exp_q    <= {RESET_ADDR[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else begin
      flight_q <= flight_q + {1'b0, acc} - {1'b0, mem_rsp_valid};
      if (mem_rsp_valid)                        stale_q <= 1'b0;
      else if (redir_valid && flight_q != 2'd0) stale_q <= 1'b1;
      if (redir_valid)  exp_q <= {redir_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      else if (acc)     exp_q <= exp_q + ADDR_W'(LINE_BYTES);
    end
  end

  assert_single_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> flight_q == 2'd0);

  assert_line_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr == exp_q);

  assert_avail_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_avail <= AVAIL_W'(2*LINE_BYTES));

  assert_consume_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rsp_valid && !redir_valid)
      |=> win_avail == $past(win_avail) - AVAIL_W'($past(take_cnt)));

  assert_redirect_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> win_avail == '0);

  assert_stale_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && stale_q && !redir_valid)
      |=> win_avail == $past(win_avail) - AVAIL_W'($past(take_cnt)));

endmodule

bind ifetch_dual_buf ifetch_dual_buf_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES), .RESET_ADDR(RESET_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
  .take_cnt(take_cnt), .win_avail(win_avail), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/ifetch_dual_buf_bench.sv
module ifetch_dual_buf_bench;

  localparam int ADDR_W = 32;
  localparam int LB     = 16;
  localparam int WB     = 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               redir_valid;
  logic [ADDR_W-1:0]  redir_addr;
  logic [2:0]         take_cnt;
  logic [WB*8-1:0]    win_bytes;
  logic [5:0]         win_avail;
  logic               mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [ADDR_W-1:0]  mem_req_addr;
  logic [LB*8-1:0]    mem_rsp_data;

  always #5 clk = ~clk;

  ifetch_dual_buf #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .WIN_BYTES(WB)) u_ifetch_dual_buf (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .take_cnt(take_cnt), .win_bytes(win_bytes), .win_avail(win_avail),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  typedef struct { int unsigned addr; int gen; int due; } pend_t;
  pend_t pend_q[$];   // scoreboard of requests in flight

  int n_chk = 0, n_bad = 0;
  int unsigned cur, endp, next_req;
  bit  end_ok;
  int  gen, cyc;
  string tag;   // requirement the next window check is attributed to

  function automatic logic [7:0] pat(int unsigned a);
    return 8'(a * 13 + (a >> 8) + 7);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_avail();
    return end_ok ? int'(endp - cur) : 0;
  endfunction

  // one clock: monitor outputs, drive stimulus, update the model after the edge
  task automatic step(int take_req, bit redir, int unsigned target, bit ready, bit redir_on_rsp);
    int  ea, held, tk;
    bit  rsp, acc, rd, exp_rv;
    pend_t e;
    @(negedge clk);
    ea = exp_avail();
    chk(int'(win_avail) == ea, {tag, " window byte count"}, int'(win_avail), ea);
    for (int i = 0; i < WB; i++)
      if (i < ea)
        chk(win_bytes[i*8 +: 8] == pat(cur + i), "R4 window byte",
            int'(win_bytes[i*8 +: 8]), int'(pat(cur + i)));
    rsp = (pend_q.size() != 0) && (pend_q[0].due <= cyc);
    rd  = redir || (redir_on_rsp && rsp);
    tk  = (take_req < ea) ? take_req : ea;
    take_cnt      = 3'(tk);
    redir_valid   = rd;
    redir_addr    = target;
    mem_req_ready = ready;
    mem_rsp_valid = rsp;
    if (rsp) for (int k = 0; k < LB; k++) mem_rsp_data[k*8 +: 8] = pat(pend_q[0].addr + k);
    #1;
    held   = end_ok ? int'((endp - (cur & ~32'hF)) / LB) : 0;
    exp_rv = (pend_q.size() == 0) && (held < 2) && !rd;
    chk(mem_req_valid == exp_rv, "R5 eager request", int'(mem_req_valid), int'(exp_rv));
    if (mem_req_valid)
      chk(mem_req_addr == next_req, (gen != 0 && !end_ok) ? "R6 target line" : "R2 line order",
          int'(mem_req_addr), int'(next_req));
    acc = mem_req_valid && ready;
    @(posedge clk);
    tag = "R3";
    if (rsp) begin
      e = pend_q.pop_front();
      if (e.gen == gen && !rd) begin end_ok = 1'b1; endp = e.addr + LB; end
      else tag = rd ? "R8" : "R7";
    end
    if (rd && tk != 0) tag = "R8";
    if (acc) begin
      pend_q.push_back('{addr: next_req, gen: gen, due: cyc + 1 + int'($urandom % 4)});
      next_req += LB;
    end
    if (rd) begin
      gen++; cur = target; end_ok = 1'b0; next_req = target & ~32'hF;
      if (tag == "R3") tag = "R6";
    end else cur += tk;
    cyc++;
  endtask

  task automatic run_main();
    rst_n = 1'b0; redir_valid = 1'b0; redir_addr = '0; take_cnt = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    cur = 0; endp = 0; end_ok = 0; next_req = 0; gen = 0; cyc = 0; tag = "R3";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(win_avail == 0, "R1 reset byte count", int'(win_avail), 0);
    chk(mem_req_valid == 1'b1, "R1 reset request", int'(mem_req_valid), 1);
    chk(mem_req_addr == 0, "R1 reset address", int'(mem_req_addr), 0);
    // fill both buffers with no consumption
    for (int n = 0; n < 24; n++) step(0, 0, 0, 1, 0);
    @(negedge clk);
    chk(win_avail == 32, "R9 both lines in order", int'(win_avail), 32);
    // steady consumption, memory stalls at random
    for (int n = 0; n < 600; n++) step(int'($urandom % 5), 0, 0, ($urandom % 4) != 0, 0);
    // random redirects, also landing on consume cycles
    for (int n = 0; n < 1500; n++)
      step(int'($urandom % 5), ($urandom % 9) == 0, $urandom & 32'h0003_FFFF,
           ($urandom % 3) != 0, 0);
    // redirect forced onto every response cycle for a while
    for (int n = 0; n < 300; n++)
      step(int'($urandom % 5), 0, $urandom & 32'h0000_FFFF, 1, (n % 20) < 10);
    // end with a clean stream and full buffers
    step(0, 1, 32'h0000_1237, 1, 0);
    for (int n = 0; n < 30; n++) step(int'($urandom % 5), 0, 0, 1, 0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule